// File: doc/BRIEF.md
# Push-Button Debounce and Status Unit

This block takes two active-low push buttons, a power key and a reset-in key, and filters each one before software sees it. Each raw input is brought into the clock domain by a short flop chain. It then has to stay at a new level for a programmable number of slow ticks before the filtered state follows it. The slow tick comes from a prescaler on the main clock and stands in for a low-frequency sleep clock. The window is set by a power-of-two code. The top code gives a window of `2^FULL_LOG2` ticks, which is two seconds at the nominal tick rate. Each code one step lower halves the window.

Software uses a byte-wide synchronous port: address, write data, write strobe and a combinational read-data bus. Through it software reads the filtered key states, controls the two pad pull-up enables, picks the filter window and handles a per-key edge interrupt. Both a press and a release set a sticky status bit. One level interrupt output is high while any enabled status bit is set.

A subtype constant, readable along with a revision constant, picks the width of the window code. Below 0x04 the code is 3 bits wide (top code 7). From 0x04 upward it is 4 bits wide (top code 15). The code resets to seven steps below its top value. That is 1/128 of the full window, about 15.6 ms at the nominal rate.

Top module: `keydb_unit`

## Requirements
- R1: After reset, the status register reads 0x00, the interrupt status and enable registers read 0x00, `irq` is 0, the pull register reads 0x03 with both pull outputs at 1, and the window code reads top code minus 7 (0 for the 3-bit code, 8 for the 4-bit code).
- R2: A key's filtered state takes a new level only after the synchronised input has held that level for P consecutive ticks. Counting clock edges from the edge after an input change, the new state is visible after between 3+(P-1)*PRESCALE and 2+P*PRESCALE edges. This is exactly P+2 edges when PRESCALE is 1.
- R3: P = 2^(FULL_LOG2 - (TOP - code)). The window code sits in the low bits of address 0x71 and is 3 bits wide (TOP=7) when SUBTYPE_VAL < 0x04, and 4 bits wide (TOP=15) otherwise. Bits above the code width read 0, and writing them has no effect.
- R4: Address 0x10 is read-only. Bit 0 is the power key's filtered state and bit 1 is the reset-in key's, with 1 meaning pressed (input low). The upper bits read 0.
- R5: Address 0x70 holds the pull-up enables. Bit 1 drives `pwr_pull_en` and bit 0 drives `rin_pull_en`. The upper bits read 0.
- R6: Address 0x01 returns REV_VAL and address 0x05 returns SUBTYPE_VAL. Writes to either address leave them unchanged, and unmapped addresses read 0x00.
- R7: Address 0x12 holds the interrupt status: bit 0 for the power key, bit 1 for the reset-in key. A bit is set by every filtered press and every filtered release. Writing 1 to a bit clears it, and bits written with 0 are kept.
- R8: Address 0x11 holds the interrupt enables, with the same bit positions. `irq` is 1 exactly while some status bit and its enable are both 1.
- R9: A write to address 0x71 restarts any window count in progress. After the write edge, the change needs a further P full ticks, that is (P-1)*PRESCALE+1 to P*PRESCALE edges.
- R10: A level change shorter than the window leaves the filtered state and the interrupt status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_key_n | input | 1 | Raw power key, low when pressed, asynchronous |
| rin_key_n | input | 1 | Raw reset-in key, low when pressed, asynchronous |
| addr | input | 8 | Register address |
| wdata | input | 8 | Register write data |
| we | input | 1 | Write strobe, write takes effect at the clock edge |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |
| pwr_pull_en | output | 1 | Power key pad pull-up enable |
| rin_pull_en | output | 1 | Reset-in key pad pull-up enable |

## Verification
Register writes show up at the negative edge right after the write edge, since `rdata` and `irq` are combinational from the registers. The bench reads back there. Filtered-state latency is measured in clock edges from the negative edge where a raw key is driven. The bench holds the address on the status register and samples every negative edge. It compares the count with the window [3+(P-1)*PRESCALE, 2+P*PRESCALE] on a narrow instance with a prescaler of 2, and with the exact value P+2 on a wide instance with no prescaler. For the restart case, the count starts at the write edge, and the bench also confirms that the state is still unchanged at the point where an unrestarted count would already have finished.

// File: rtl/keydb_pkg.sv
// Package: keydb_pkg
// Shared register addresses, key indices and the code-width rule for the
// push-button debounce unit. Assumes an 8-bit register address space.
package keydb_pkg;

    localparam logic [7:0] ADDR_REV     = 8'h01;
    localparam logic [7:0] ADDR_SUBTYPE = 8'h05;
    localparam logic [7:0] ADDR_STAT    = 8'h10;
    localparam logic [7:0] ADDR_IEN     = 8'h11;
    localparam logic [7:0] ADDR_ISTS    = 8'h12;
    localparam logic [7:0] ADDR_PULL    = 8'h70;
    localparam logic [7:0] ADDR_DBC     = 8'h71;

    localparam int NUM_KEYS = 2;
    localparam int KEY_PWR  = 0;
    localparam int KEY_RIN  = 1;

    localparam logic [7:0] WIDE_SUBTYPE_MIN = 8'h04;

    // Width of the window code selected by the subtype strap.
    function automatic int code_width(input logic [7:0] subtype);
        return (subtype >= WIDE_SUBTYPE_MIN) ? 4 : 3;
    endfunction

endpackage

// File: rtl/keydb_sync.sv
// Module: keydb_sync
// Flop chain that brings one asynchronous bit into the clk domain.
// Assumes STAGES >= 2; resets to 0 (key released).
module keydb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw bit through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/keydb_tick.sv
// Module: keydb_tick
// Divides clk by PRESCALE into a one-cycle slow tick (sleep-clock stand-in).
// With PRESCALE <= 1 every clock cycle is a tick.
module keydb_tick #(
    parameter int PRESCALE = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (PRESCALE <= 1) begin : g_pass
            logic unused_in;
            assign unused_in = clk ^ rst_n;
            assign tick      = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pcnt_q;

            // Free-running modulo-PRESCALE counter.
            always_ff @(posedge clk) begin
                if (!rst_n)              pcnt_q <= '0;
                else if (pcnt_q == LAST) pcnt_q <= '0;
                else                     pcnt_q <= pcnt_q + PW'(1);
            end

            assign tick = (pcnt_q == LAST);

            // R2: the tick counter never leaves its modulo range.
            a_r2_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
                int'(pcnt_q) < PRESCALE);
        end
    endgenerate

endmodule

// File: rtl/keydb_filter.sv
// Module: keydb_filter
// Debounce filter for one synchronised key. The state follows samp only
// after samp has differed from it for P ticks, P = 2^(FULL_LOG2-(TOP-code)).
// Assumes FULL_LOG2 >= TOP so that P >= 1. restart clears the count.
module keydb_filter #(
    parameter int CODE_W    = 3,
    parameter int FULL_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    input  logic              samp,
    output logic              state,
    output logic              flip
);

    localparam int TOP     = (1 << CODE_W) - 1;
    localparam int SH_BASE = FULL_LOG2 - TOP;
    localparam int CW      = FULL_LOG2 + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] lim;
    logic [CW-1:0] cnt_q;
    logic          commit;

    // Window length in ticks for the current code.
    assign lim = ONE << (SH_BASE + int'(code));

    // Decide whether this cycle ends a full stable window.
    always_comb begin
        commit = !restart && (samp != state) && tick && (cnt_q == lim - ONE);
    end

    // Count ticks while the input disagrees with the state; commit at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            state <= 1'b0;
        end else if (restart || (samp == state)) begin
            cnt_q <= '0;
        end else if (commit) begin
            cnt_q <= '0;
            state <= samp;
        end else if (tick) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign flip = commit;

    // R2: the state only ever moves to the level the input had.
    a_r2_follow_input: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state) |-> (state == $past(samp)));

    // R2: the tick count stays inside the window.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < lim);

    // R9: a restart leaves the count at zero.
    a_r9_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/keydb_unit.sv
// Module: keydb_unit
// Top of the push-button debounce unit: two synchronised, debounced keys,
// a byte-wide register file (status, pulls, window code, interrupt status
// and enable, read-only identity) and a level interrupt.
// Assumes a synchronous register port; rdata is combinational from addr.
module keydb_unit
    import keydb_pkg::*;
#(
    parameter logic [7:0] REV_VAL     = 8'h02,
    parameter logic [7:0] SUBTYPE_VAL = 8'h04,
    parameter int         FULL_LOG2   = 16,
    parameter int         PRESCALE    = 586,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_key_n,
    input  logic       rin_key_n,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       we,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       pwr_pull_en,
    output logic       rin_pull_en
);

    localparam int CODE_W = code_width(SUBTYPE_VAL);
    localparam int TOP    = (1 << CODE_W) - 1;
    localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(TOP - 7);

    logic [NUM_KEYS-1:0] keys_n;
    logic [NUM_KEYS-1:0] samp;
    logic [NUM_KEYS-1:0] db;
    logic [NUM_KEYS-1:0] flip;
    logic                tick;

    logic [CODE_W-1:0]   dbc_q;
    logic [1:0]          pull_q;
    logic [NUM_KEYS-1:0] ien_q;
    logic [NUM_KEYS-1:0] ists_q;

    logic wr_dbc, wr_pull, wr_ien, wr_ists;
    logic unused_wdata_hi;

    assign keys_n[KEY_PWR]  = pwr_key_n;
    assign keys_n[KEY_RIN]  = rin_key_n;
    assign unused_wdata_hi  = ^wdata[7:3];

    // Write decode for the writable registers.
    always_comb begin
        wr_dbc  = we && (addr == ADDR_DBC);
        wr_pull = we && (addr == ADDR_PULL);
        wr_ien  = we && (addr == ADDR_IEN);
        wr_ists = we && (addr == ADDR_ISTS);
    end

    keydb_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
            keydb_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (~keys_n[k]),
                .dout  (samp[k])
            );

            keydb_filter #(.CODE_W(CODE_W), .FULL_LOG2(FULL_LOG2)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .restart (wr_dbc),
                .code    (dbc_q),
                .samp    (samp[k]),
                .state   (db[k]),
                .flip    (flip[k])
            );
        end
    endgenerate

    // Control registers: window code, pull-ups and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbc_q  <= RST_CODE;
            pull_q <= 2'b11;
            ien_q  <= '0;
        end else begin
            if (wr_dbc)  dbc_q  <= wdata[CODE_W-1:0];
            if (wr_pull) pull_q <= wdata[1:0];
            if (wr_ien)  ien_q  <= wdata[NUM_KEYS-1:0];
        end
    end

    // Sticky edge status: set by any filtered edge, cleared by writing 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       ists_q <= '0;
        else if (wr_ists) ists_q <= (ists_q & ~wdata[NUM_KEYS-1:0]) | flip;
        else              ists_q <= ists_q | flip;
    end

    // Read mux for the register port.
    always_comb begin
        rdata = 8'h00;
        case (addr)
            ADDR_REV:     rdata = REV_VAL;
            ADDR_SUBTYPE: rdata = SUBTYPE_VAL;
            ADDR_STAT:    rdata = 8'(db);
            ADDR_IEN:     rdata = 8'(ien_q);
            ADDR_ISTS:    rdata = 8'(ists_q);
            ADDR_PULL:    rdata = 8'(pull_q);
            ADDR_DBC:     rdata = 8'(dbc_q);
            default:      rdata = 8'h00;
        endcase
    end

    assign irq         = |(ists_q & ien_q);
    assign pwr_pull_en = pull_q[1];
    assign rin_pull_en = pull_q[0];

    // R7: every filtered edge leaves its status bit set.
    a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((ists_q & $past(flip)) == $past(flip)));

    // R7: a status bit falls only through a write of 1 to it.
    a_r7_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ists_q[KEY_PWR]) |-> $past(wr_ists && wdata[KEY_PWR]));

    // R8: the interrupt rises only after an edge or a register write.
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|flip) || $past(we)));

    // R5: the pull enables change only through their register.
    a_r5_pull_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_q) |-> $past(wr_pull));

    // R3: the window code changes only through its register.
    a_r3_code_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbc_q) |-> $past(wr_dbc));

endmodule

// File: tb/keydb_unit_bench.sv
// Bench for keydb_unit: a narrow (3-bit code, prescaler 2) instance and a
// wide (4-bit code, no prescaler) instance, with latencies computed here.
module keydb_unit_bench;
    import keydb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PS_N = 2;
    localparam int FL_N = 7;
    localparam int FL_W = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_n = 1'b1, rin_n = 1'b1, pwr_w_n = 1'b1, rin_w_n = 1'b1;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic       we = 1'b0, we_w = 1'b0;
    logic [7:0] rdata, rdata_w;
    logic       irq, irq_w, ppu, rpu, ppu_w, rpu_w;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keydb_unit #(.REV_VAL(8'h02), .SUBTYPE_VAL(8'h01), .FULL_LOG2(FL_N),
                 .PRESCALE(PS_N), .SYNC_STAGES(2)) u_keydb_unit (
        .clk(clk), .rst_n(rst_n), .pwr_key_n(pwr_n), .rin_key_n(rin_n),
        .addr(addr), .wdata(wdata), .we(we), .rdata(rdata), .irq(irq),
        .pwr_pull_en(ppu), .rin_pull_en(rpu));

    keydb_unit #(.REV_VAL(8'h03), .SUBTYPE_VAL(8'h05), .FULL_LOG2(FL_W),
                 .PRESCALE(1), .SYNC_STAGES(2)) u_keydb_unit_wide (
        .clk(clk), .rst_n(rst_n), .pwr_key_n(pwr_w_n), .rin_key_n(rin_w_n),
        .addr(addr), .wdata(wdata), .we(we_w), .rdata(rdata_w), .irq(irq_w),
        .pwr_pull_en(ppu_w), .rin_pull_en(rpu_w));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit wide);
        @(negedge clk);
        addr = a; wdata = d;
        if (wide) we_w = 1'b1; else we = 1'b1;
        @(negedge clk);
        we = 1'b0; we_w = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v, output logic [7:0] vw);
        addr = a;
        #1;
        v = rdata; vw = rdata_w;
    endtask

    // Drive a key and count edges until the filtered state shows it.
    task automatic lat(input bit wide, input int k, input bit press, output int n);
        logic [7:0] v;
        @(negedge clk);
        addr = ADDR_STAT;
        if (!wide) begin
            if (k == KEY_PWR) pwr_n = !press; else rin_n = !press;
        end else begin
            if (k == KEY_PWR) pwr_w_n = !press; else rin_w_n = !press;
        end
        n = 0;
        do begin
            @(negedge clk);
            n++;
            v = wide ? rdata_w : rdata;
        end while (v[k] !== press && n < 1000);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v, vw;
        int n, p, lo, hi, m;
        bit seen;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(ADDR_STAT, v, vw);  chk(v == 0 && vw == 0, "R1 status", v, 0);
        rd(ADDR_ISTS, v, vw);  chk(v == 0 && vw == 0, "R1 int status", v, 0);
        rd(ADDR_IEN, v, vw);   chk(v == 0 && vw == 0, "R1 int enable", v, 0);
        chk(irq == 0 && irq_w == 0, "R1 irq", irq, 0);
        rd(ADDR_PULL, v, vw);  chk(v == 3 && vw == 3, "R1 pull reg", v, 3);
        chk(ppu && rpu && ppu_w && rpu_w, "R1 pull outputs", {ppu, rpu}, 3);
        rd(ADDR_DBC, v, vw);   chk(v == 0, "R1 narrow code", v, 0);
        chk(vw == 8, "R1 wide code", vw, 8);

        // R6 identity registers, read-only, unmapped reads
        rd(ADDR_REV, v, vw);     chk(v == 8'h02 && vw == 8'h03, "R6 revision", v, 2);
        rd(ADDR_SUBTYPE, v, vw); chk(v == 8'h01 && vw == 8'h05, "R6 subtype", v, 1);
        wr(ADDR_REV, 8'hAA, 0); wr(ADDR_SUBTYPE, 8'hAA, 0);
        wr(ADDR_REV, 8'h55, 1); wr(ADDR_SUBTYPE, 8'h55, 1);
        rd(ADDR_REV, v, vw);     chk(v == 8'h02 && vw == 8'h03, "R6 revision after write", v, 2);
        rd(ADDR_SUBTYPE, v, vw); chk(v == 8'h01 && vw == 8'h05, "R6 subtype after write", v, 1);
        rd(8'h33, v, vw);        chk(v == 0 && vw == 0, "R6 unmapped read", v, 0);

        // R5 pull register
        wr(ADDR_PULL, 8'h02, 0);
        rd(ADDR_PULL, v, vw); chk(v == 8'h02, "R5 pull reg 02", v, 2);
        chk(ppu == 1 && rpu == 0, "R5 pull outputs 02", {ppu, rpu}, 2);
        wr(ADDR_PULL, 8'hFD, 0);
        rd(ADDR_PULL, v, vw); chk(v == 8'h01, "R5 pull upper bits", v, 1);
        chk(ppu == 0 && rpu == 1, "R5 pull outputs 01", {ppu, rpu}, 1);

        // R3 code masking
        wr(ADDR_DBC, 8'hFF, 0); wr(ADDR_DBC, 8'hFF, 1);
        rd(ADDR_DBC, v, vw);
        chk(v == 8'h07, "R3 narrow code width", v, 7);
        chk(vw == 8'h0F, "R3 wide code width", vw, 15);

        // R8 / R7 interrupt handling with code 0
        wr(ADDR_DBC, 8'h00, 0);
        lat(0, KEY_PWR, 1, n);
        @(negedge clk);
        chk(irq == 0, "R8 irq masked", irq, 0);
        rd(ADDR_ISTS, v, vw); chk(v == 8'h01, "R7 press sets bit0", v, 1);
        wr(ADDR_IEN, 8'h01, 0);
        chk(irq == 1, "R8 irq enabled", irq, 1);
        wr(ADDR_ISTS, 8'h02, 0);
        rd(ADDR_ISTS, v, vw); chk(v == 8'h01, "R7 write 0 keeps bit", v, 1);
        wr(ADDR_ISTS, 8'h01, 0);
        rd(ADDR_ISTS, v, vw); chk(v == 8'h00, "R7 write 1 clears", v, 0);
        chk(irq == 0, "R8 irq after clear", irq, 0);
        lat(0, KEY_PWR, 0, n);
        rd(ADDR_ISTS, v, vw); chk(v == 8'h01, "R7 release sets bit0", v, 1);
        wr(ADDR_ISTS, 8'h03, 0);
        wr(ADDR_IEN, 8'h03, 0);

        // R2/R3/R4/R7/R8 sweep over all narrow codes and both keys
        for (int c = 0; c < 8; c++) begin
            wr(ADDR_DBC, 8'(c), 0);
            p  = 1 << (FL_N - 7 + c);
            lo = 3 + (p - 1) * PS_N;
            hi = 2 + p * PS_N;
            for (int k = 0; k < 2; k++) begin
                lat(0, k, 1, n);
                chk(n >= lo && n <= hi, $sformatf("R2 R3 press code %0d key %0d", c, k), n, hi);
                rd(ADDR_STAT, v, vw);
                chk(v == 8'(1 << k), $sformatf("R4 status map key %0d", k), v, 1 << k);
                chk(irq == 1, "R8 irq on press", irq, 1);
                wr(ADDR_ISTS, 8'h03, 0);
                lat(0, k, 0, n);
                chk(n >= lo && n <= hi, $sformatf("R2 R3 release code %0d key %0d", c, k), n, hi);
                rd(ADDR_ISTS, v, vw);
                chk(v == 8'(1 << k), $sformatf("R7 release edge key %0d", k), v, 1 << k);
                wr(ADDR_ISTS, 8'h03, 0);
            end
        end

        // R10 short glitch rejected (code 4: 16 ticks = 32 cycles)
        wr(ADDR_DBC, 8'h04, 0);
        @(negedge clk);
        addr = ADDR_STAT;
        rin_n = 1'b0;
        seen = 1'b0;
        repeat (10) begin @(negedge clk); if (rdata[KEY_RIN]) seen = 1'b1; end
        rin_n = 1'b1;
        repeat (80) begin @(negedge clk); if (rdata[KEY_RIN]) seen = 1'b1; end
        chk(!seen, "R10 glitch status", seen, 0);
        rd(ADDR_ISTS, v, vw); chk(v == 0, "R10 glitch int status", v, 0);

        // R9 restart by code write (code 5: 32 ticks = 64 cycles)
        wr(ADDR_DBC, 8'h05, 0);
        @(negedge clk);
        addr = ADDR_STAT;
        pwr_n = 1'b0;
        repeat (40) @(negedge clk);
        chk(rdata[KEY_PWR] == 0, "R9 not yet pressed", rdata[KEY_PWR], 0);
        wr(ADDR_DBC, 8'h05, 0);
        addr = ADDR_STAT;
        m = 0;
        seen = 1'b0;
        do begin
            @(negedge clk);
            m++;
            if (m == 62 && rdata[KEY_PWR]) seen = 1'b1;
        end while (rdata[KEY_PWR] !== 1'b1 && m < 500);
        chk(!seen, "R9 held after restart", seen, 0);
        chk(m >= 63 && m <= 64, "R9 restart latency", m, 64);
        lat(0, KEY_PWR, 0, n);
        wr(ADDR_ISTS, 8'h03, 0);

        // R2/R3 wide instance: exact P+2 edges, P = 2^code
        wr(ADDR_DBC, 8'h00, 1);
        lat(1, KEY_PWR, 1, n); chk(n == 3, "R2 R3 wide code 0", n, 3);
        wr(ADDR_DBC, 8'h03, 1);
        lat(1, KEY_PWR, 0, n); chk(n == 10, "R2 R3 wide code 3", n, 10);
        wr(ADDR_DBC, 8'h08, 1);
        lat(1, KEY_RIN, 1, n); chk(n == 258, "R2 R3 wide code 8", n, 258);
        rd(ADDR_STAT, v, vw);  chk(vw == 8'h02, "R4 wide status map", vw, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule